// File: doc/BRIEF.md
# Locked Rotor Protection Timer

This block guards a brushless motor drive against a stalled rotor. A slow timing oscillator outside the block delivers ticks, and the hall decoding logic delivers one pulse per completed electrical revolution. While the drive is active, the block counts oscillator ticks and clears the count on each revolution pulse. A rotor that turns keeps the count low. A rotor that is held still lets the count reach the detection limit. At that point the block enters a protected state and forces every high-side and low-side gate command low.

Once protected, the same counter times an off period. This period is eleven times the detection window at the default limits (2816 ticks against 256). When it ends, the drive is re-enabled automatically. With a typical 8.36 ms tick, detection takes about 2.14 s and recovery about 23.54 s.

Three conditions end protection at once and clear the count:
- the control level falls below the running threshold;
- the thermistor input reads low;
- the rotation direction input changes.

An active thermal shutdown only freezes the count and the state.

Top module: `stall_guard`

## Requirements
- R1: While not protected and with the drive active, each rising edge of the oscillator tick adds one to the count. A rising edge of the revolution pulse clears the count to 0.
- R2: The DETECT_TICKS-th tick (default 256) counted without a clear sets the protect output to 1 and restarts the count at 0. While protect is 1, all high-side and low-side gate outputs are 0.
- R3: While protected, the RECOVER_TICKS-th tick (default 2816) returns the protect output to 0 and the count to 0.
- R4: The control-low input at 1 clears protection and the count on the next clock edge.
- R5: The thermistor-low input at 1 clears protection and the count on the next clock edge.
- R6: A change of level on the direction input, in either direction, clears protection and the count.
- R7: While the thermal shutdown input is 1, ticks change neither the count nor the protect output. The release conditions of R4 to R6 still take effect and take priority over the freeze.
- R8: While not protected and with the drive-active input at 0, ticks leave the count unchanged.
- R9: While protected, revolution pulses leave the count unchanged.
- R10: While protect is 0, each gate output equals its gate input.
- R11: After reset, the count is 0 and protect is 0.
- R12: The tick, revolution and direction inputs are synchronised to the clock. A tick held high for many cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | Timing oscillator tick, asynchronous; rising edge counts |
| rev_pulse_i | input | 1 | One pulse per electrical revolution, asynchronous |
| dir_i | input | 1 | Rotation direction input, asynchronous; any change releases |
| drive_en_i | input | 1 | Drive active flag |
| ctl_low_i | input | 1 | Control level below running threshold |
| therm_low_i | input | 1 | Thermistor input low |
| tsd_i | input | 1 | Thermal shutdown active |
| hi_i | input | PHASES | High-side gate commands |
| lo_i | input | PHASES | Low-side gate commands |
| hi_o | output | PHASES | Masked high-side gate outputs |
| lo_o | output | PHASES | Masked low-side gate outputs |
| protect_o | output | 1 | Locked rotor protection active |
| count_o | output | CNT_W | Current tick count of the active window |

## Verification
The bench drives the count to exactly one tick below each limit and then adds the final tick. A design off by one would either trip or release a tick early, or miss the limit and run past it.

It also checks several behaviours a faulty design would get wrong:
- A tick held high for many cycles must count once; a design missing edge detection would count on every cycle.
- Thermal shutdown must freeze the count without clearing it, and a release that arrives during the freeze must still clear it.
- Ticks with the drive inactive, and revolution pulses while protected, must leave the count unchanged; a design that counted or cleared there would drift away from the expected value.

Each release source is applied from inside the protected state after a few off-period ticks, so a release that failed to clear the count shows a nonzero value.

// File: rtl/stall_pkg.sv
package stall_pkg;

    // Operating mode of the locked rotor timer
    typedef enum logic [0:0] {
        MODE_WATCH = 1'b0,   // rotor watched, counting towards detection
        MODE_OFF   = 1'b1    // drive blocked, counting towards recovery
    } mode_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/stall_sync.sv
module stall_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;
        logic              prev_d, prev_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
            prev_d  = chain_q[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= chain_d;
                prev_q  <= prev_d;
            end
        end

        assign level_o[g] = chain_q[STAGES-1];
        assign rise_o[g]  = chain_q[STAGES-1] & ~prev_q;
        assign fall_o[g]  = ~chain_q[STAGES-1] & prev_q;

        // R12: a detected edge lasts exactly one cycle
        a_r12_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g]);
    end

endmodule

// File: rtl/stall_timer.sv
module stall_timer
    import stall_pkg::*;
#(
    parameter int DETECT_TICKS  = 256,
    parameter int RECOVER_TICKS = 2816,
    parameter int CNT_W         = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rev_i,
    input  logic             drive_en_i,
    input  logic             release_i,
    input  logic             freeze_i,
    output mode_e            mode_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] DETECT_LAST  = CNT_W'(DETECT_TICKS - 1);
    localparam logic [CNT_W-1:0] RECOVER_LAST = CNT_W'(RECOVER_TICKS - 1);

    typedef struct packed {
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (release_i) begin
            st_d.mode = MODE_WATCH;
            st_d.cnt  = '0;
        end else if (!freeze_i) begin
            unique case (st_q.mode)
                MODE_WATCH: begin
                    if (rev_i) begin
                        st_d.cnt = '0;
                    end else if (drive_en_i && tick_i) begin
                        if (st_q.cnt == DETECT_LAST) begin
                            st_d.mode = MODE_OFF;
                            st_d.cnt  = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                MODE_OFF: begin
                    if (tick_i) begin
                        if (st_q.cnt == RECOVER_LAST) begin
                            st_d.mode = MODE_WATCH;
                            st_d.cnt  = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_WATCH, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign cnt_o  = st_q.cnt;

    // R2: entering protection only follows the last detection tick
    a_r2_enter_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.mode == MODE_OFF) |-> ($past(st_q.cnt) == DETECT_LAST && $past(tick_i)));

    // R3: the count never exceeds the window of the current mode
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_OFF) ? (st_q.cnt <= RECOVER_LAST) : (st_q.cnt <= DETECT_LAST));

    // R4 R5 R6: any release leaves the block watching with a cleared count
    a_r4_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> (st_q.mode == MODE_WATCH && st_q.cnt == '0));

    // R7: thermal shutdown without release freezes the timer
    a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !release_i) |=> ($stable(st_q.cnt) && $stable(st_q.mode)));

    // R8: an inactive drive stops counting while watching
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_WATCH && !drive_en_i && !rev_i && !release_i) |=> $stable(st_q.cnt));

    // R9: revolutions do not disturb the off period count
    a_r9_rev_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_OFF && rev_i && !tick_i && !release_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/stall_guard.sv
module stall_guard
    import stall_pkg::*;
#(
    parameter int DETECT_TICKS  = 256,
    parameter int RECOVER_TICKS = 2816,
    parameter int SYNC_STAGES   = 2,
    parameter int PHASES        = 3,
    localparam int CNT_W        = $clog2(stall_pkg::max_of(DETECT_TICKS, RECOVER_TICKS))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick_i,
    input  logic              rev_pulse_i,
    input  logic              dir_i,
    input  logic              drive_en_i,
    input  logic              ctl_low_i,
    input  logic              therm_low_i,
    input  logic              tsd_i,
    input  logic [PHASES-1:0] hi_i,
    input  logic [PHASES-1:0] lo_i,
    output logic [PHASES-1:0] hi_o,
    output logic [PHASES-1:0] lo_o,
    output logic              protect_o,
    output logic [CNT_W-1:0]  count_o
);

    localparam int N_SYNC = 3;
    localparam int IDX_TICK = 0;
    localparam int IDX_REV  = 1;
    localparam int IDX_DIR  = 2;

    logic [N_SYNC-1:0] async_vec, level_vec, rise_vec, fall_vec;
    logic              dir_change;
    logic              release_req;
    mode_e             mode;

    assign async_vec = {dir_i, rev_pulse_i, osc_tick_i};

    stall_sync #(
        .WIDTH  (N_SYNC),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_vec),
        .level_o (level_vec),
        .rise_o  (rise_vec),
        .fall_o  (fall_vec)
    );

    assign dir_change  = rise_vec[IDX_DIR] | fall_vec[IDX_DIR];
    assign release_req = ctl_low_i | therm_low_i | dir_change;

    stall_timer #(
        .DETECT_TICKS  (DETECT_TICKS),
        .RECOVER_TICKS (RECOVER_TICKS),
        .CNT_W         (CNT_W)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (rise_vec[IDX_TICK]),
        .rev_i      (rise_vec[IDX_REV]),
        .drive_en_i (drive_en_i),
        .release_i  (release_req),
        .freeze_i   (tsd_i),
        .mode_o     (mode),
        .cnt_o      (count_o)
    );

    assign protect_o = (mode == MODE_OFF);
    assign hi_o      = protect_o ? '0 : hi_i;
    assign lo_o      = protect_o ? '0 : lo_i;

    // R6: a direction change seen by the synchroniser ends protection
    a_r6_dir_release: assert property (@(posedge clk) disable iff (!rst_n)
        (level_vec[IDX_DIR] != $past(level_vec[IDX_DIR])) |=> !protect_o);

endmodule

// File: tb/test_stall_guard.sv
module test_stall_guard;

    localparam int CLK_PERIOD = 10;
    localparam int PH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_tick_i = 1'b0;
    logic          rev_pulse_i = 1'b0;
    logic          dir_i = 1'b0;
    logic          drive_en_i = 1'b0;
    logic          ctl_low_i = 1'b0;
    logic          therm_low_i = 1'b0;
    logic          tsd_i = 1'b0;
    logic [PH-1:0] hi_i = '0;
    logic [PH-1:0] lo_i = '0;
    logic [PH-1:0] hi_o, lo_o;
    logic          protect_o;
    logic [11:0]   count_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stall_guard i_stall_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_tick_i  (osc_tick_i),
        .rev_pulse_i (rev_pulse_i),
        .dir_i       (dir_i),
        .drive_en_i  (drive_en_i),
        .ctl_low_i   (ctl_low_i),
        .therm_low_i (therm_low_i),
        .tsd_i       (tsd_i),
        .hi_i        (hi_i),
        .lo_i        (lo_i),
        .hi_o        (hi_o),
        .lo_o        (lo_o),
        .protect_o   (protect_o),
        .count_o     (count_o)
    );

    // ticks, drive_en, rev after ticks, expected count, expected protect
    localparam int VEC [8][5] = '{
        '{  10, 1, 0,   10, 0},   // R1 counting
        '{   5, 0, 0,   10, 0},   // R8 drive inactive holds
        '{   0, 1, 1,    0, 0},   // R1 revolution clears
        '{ 255, 1, 0,  255, 0},   // R2 one below detection
        '{   1, 1, 0,    0, 1},   // R2 detection trips
        '{   3, 1, 1,    3, 1},   // R9 revolution ignored while off
        '{2812, 1, 0, 2815, 1},   // R3 one below recovery
        '{   1, 1, 0,    0, 0}    // R3 automatic recovery
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input int exp_cnt, input int exp_prot);
        check(int'(count_o) == exp_cnt, req, int'(count_o), exp_cnt);
        check(int'(protect_o) == exp_prot, req, int'(protect_o), exp_prot);
    endtask

    task automatic tick(input int high_cycles = 3);
        osc_tick_i = 1'b1;
        repeat (high_cycles) @(negedge clk);
        osc_tick_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic rev();
        rev_pulse_i = 1'b1;
        repeat (3) @(negedge clk);
        rev_pulse_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic go_protect();
        rev();
        ticks(256);
    endtask

    task automatic pulse_level(ref logic sig);
        sig = 1'b1;
        repeat (2) @(negedge clk);
        sig = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        hi_i = 3'b101;
        lo_i = 3'b010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check_state("R11", 0, 0);
        // R10 gates pass when not protected
        check(hi_o == hi_i, "R10", int'(hi_o), int'(hi_i));
        check(lo_o == lo_i, "R10", int'(lo_o), int'(lo_i));

        for (int v = 0; v < 8; v++) begin
            drive_en_i = VEC[v][1][0];
            ticks(VEC[v][0]);
            if (VEC[v][2] != 0) rev();
            if (v == 4) begin
                // R2 gates forced low while protected
                check(hi_o == '0, "R2", int'(hi_o), 0);
                check(lo_o == '0, "R2", int'(lo_o), 0);
            end
            check_state($sformatf("R%0d vec%0d", (v < 3) ? 1 : (v < 5 ? 2 : 3), v),
                        VEC[v][3], VEC[v][4]);
        end
        drive_en_i = 1'b1;

        // R12 a long tick counts once
        tick(20);
        check_state("R12", 1, 0);

        // R7 thermal shutdown freezes
        ticks(3);
        tsd_i = 1'b1;
        ticks(5);
        check_state("R7 freeze", 4, 0);
        tsd_i = 1'b0;
        tick();
        check_state("R7 resume", 5, 0);

        // R7 release overrides freeze
        tsd_i = 1'b1;
        pulse_level(ctl_low_i);
        check_state("R7 release priority", 0, 0);
        tsd_i = 1'b0;

        // R4 control low releases
        go_protect();
        ticks(3);
        check_state("R4 before", 3, 1);
        pulse_level(ctl_low_i);
        check_state("R4", 0, 0);

        // R5 thermistor low releases
        go_protect();
        ticks(4);
        pulse_level(therm_low_i);
        check_state("R5", 0, 0);

        // R6 direction change releases
        go_protect();
        ticks(2);
        dir_i = 1'b1;
        repeat (6) @(negedge clk);
        check_state("R6 rise", 0, 0);
        go_protect();
        dir_i = 1'b0;
        repeat (6) @(negedge clk);
        check_state("R6 fall", 0, 0);

        // R7 freeze while protected
        go_protect();
        ticks(2);
        tsd_i = 1'b1;
        ticks(4);
        check_state("R7 off freeze", 2, 1);
        tsd_i = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule